// File: doc/BRIEF.md
# Three-Level Bridge Gate Pattern Generator

This block turns six modulation references into the twelve gate commands of a three-phase, three-level neutral-clamped bridge. Each phase leg has four series switches, named T1 (outermost, positive side) to T4 (outermost, negative side). T1 and T3 are driven as one complementary pair and T2 and T4 as another. Every leg receives two references, each a fraction in [0,1]: one for the outer pair (T1/T3) and one for the inner pair (T2/T4). It also receives a clamp code, which can hold the leg at a fixed level for a whole region. When a leg is held this way, its four switches stop toggling, so at most eight of the twelve switches toggle at the carrier rate.

A single up/down counter acts as the triangular carrier for all six comparisons. References and clamp codes are captured only at the two turning points of the carrier. Each comparison result feeds a dead-time stage for its pair. A global enable forces every gate off within one clock. When the enable returns, each pair passes through a full dead time before it turns a gate on.

Top module: `npc_gate_gen`

## Requirements
- R1: The carrier counts 0, 1, ..., P, P-1, ..., 1, 0 and repeats, so its period is 2P clocks. P is `peak_i`, sampled only in cycles where the carrier is 0. Reset sets the carrier to 0 with a stored peak of 0.
- R2: A reference r is read as r/2^RW. Values above 2^RW saturate to 2^RW. The threshold is floor(min(r,2^RW)*(P+1)/2^RW), and the pair command is 1 while the threshold is greater than the carrier. A reference of 0 therefore never commands on, and a reference of 2^RW always does. In steady state with no dead time, a threshold t gives an on-time per period of 0 for t=0, 2t-1 for 1<=t<=P, and 2P for t=P+1.
- R3: Thresholds and clamp codes are captured only on clock edges where the carrier equals 0 or the stored peak. A reference change between those points has no effect until the next such edge.
- R4: `gate_o[leg]` bit 0 is T1, bit 1 is T2, bit 2 is T3 and bit 3 is T4. The outer command drives T1 (and its inverse drives T3). The inner command drives T2 (and its inverse drives T4).
- R5: When a pair's command changes, both of its gates are off from the next edge. The newly selected gate turns on `dead_i` clocks after that edge. With `dead_i` = 0 the two gates swap at the same edge.
- R6: T1 and T4 of a leg are never on together. While the outer command is 1, the inner command is forced to 1.
- R7: Clamp code 0 leaves the leg free. Code 1 holds T1 and T2 on. Code 2 holds T3 and T4 on. Code 3 holds T2 and T3 on. A clamped leg's gates do not change while the code stays the same.
- R8: With `en_i` low, all twelve gates are low from the next edge. After `en_i` returns high, the first edge leaves all gates off, and each pair's gate turns on `dead_i` clocks after that edge.
- R9: During and right after reset all gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global gate enable |
| peak_i | input | CW | Carrier peak value P |
| dead_i | input | DTW | Dead time in clocks |
| ref_a_i | input | 3 x (RW+1) | Outer-pair reference per leg |
| ref_b_i | input | 3 x (RW+1) | Inner-pair reference per leg |
| clamp_i | input | 3 x 2 | Clamp code per leg |
| gate_o | output | 3 x 4 | Gate commands, bits T1..T4 per leg |

## Verification
A wrong carrier shows up at once as the wrong duty on every leg, and the on-time counted over one carrier period no longer matches the arithmetic formula. A wrong threshold latch, or a wrong dead-time counter, makes a gate edge land on a different clock from the one the bench computes. The bench compares all twelve gates every cycle against a model driven only by the requirements, so any such error is flagged on the first clock where it differs. Shoot-through between T1 and T4, a clamped leg that moves, and gates that remain on one clock after the enable drops are each also reported in the cycle where they occur.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int NLEG = 3;

  typedef enum logic [1:0] {
    CLP_FREE = 2'd0,
    CLP_POS  = 2'd1,
    CLP_NEG  = 2'd2,
    CLP_MID  = 2'd3
  } clamp_e;

  localparam int SW_T1 = 0;
  localparam int SW_T2 = 1;
  localparam int SW_T3 = 2;
  localparam int SW_T4 = 3;
endpackage

// File: rtl/npc_carrier.sv
module npc_carrier #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] peak_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] peak_o,
  output logic          strobe_o
);
  logic [CW-1:0] cnt_q, peak_q;
  logic          up_q;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      peak_q <= '0;
      up_q   <= 1'b1;
    end else begin
      if (at_zero) peak_q <= peak_i;
      if (at_zero) begin
        up_q  <= 1'b1;
        cnt_q <= (peak_q != '0) ? CW'(1) : '0;
      end else if (up_q && cnt_q >= peak_q) begin
        up_q  <= 1'b0;
        cnt_q <= cnt_q - CW'(1);
      end else begin
        cnt_q <= up_q ? cnt_q + CW'(1) : cnt_q - CW'(1);
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign peak_o   = peak_q;
  assign strobe_o = at_zero || (cnt_q == peak_q);

  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= peak_q);

  assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == $past(cnt_q) + CW'(1)) || (cnt_q == $past(cnt_q) - CW'(1)) ||
    (cnt_q == '0 && $past(cnt_q) == '0));
endmodule

// File: rtl/npc_dt_pair.sv
module npc_dt_pair #(
  parameter int DTW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           cmd_i,
  input  logic [DTW-1:0] dead_i,
  output logic           hi_o,
  output logic           lo_o
);
  logic           want_q;
  logic [DTW-1:0] tmr_q;
  logic           idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      want_q <= 1'b0;
      tmr_q  <= '0;
    end else if (!run_i || (cmd_i != want_q)) begin
      want_q <= cmd_i;
      tmr_q  <= dead_i;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - DTW'(1);
    end
  end

  assign idle = (tmr_q == '0);
  assign hi_o = run_i & idle & want_q;
  assign lo_o = run_i & idle & ~want_q;
endmodule

// File: rtl/npc_leg.sv
module npc_leg
  import npc_pkg::*;
#(
  parameter int CW  = 12,
  parameter int RW  = 12,
  parameter int DTW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           strobe_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic [CW-1:0]  peak_i,
  input  logic [DTW-1:0] dead_i,
  input  logic [RW:0]    ref_a_i,
  input  logic [RW:0]    ref_b_i,
  input  logic [1:0]     clamp_i,
  output logic [3:0]     gate_o
);
  localparam int PW = RW + CW + 2;
  localparam logic [RW:0] ONE = {1'b1, {RW{1'b0}}};

  logic [1:0][RW:0] ref_in;
  logic [1:0][CW:0] thr_q;
  logic [1:0]       hit;
  logic [1:0]       cmd;
  clamp_e           clp_q;

  assign ref_in[0] = ref_a_i;
  assign ref_in[1] = ref_b_i;

  for (genvar k = 0; k < 2; k++) begin : g_ref
    logic [RW:0]   sat;
    logic [PW-1:0] prod;
    assign sat  = (ref_in[k] > ONE) ? ONE : ref_in[k];
    assign prod = PW'(sat) * PW'({1'b0, peak_i} + (CW+1)'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       thr_q[k] <= '0;
      else if (strobe_i) thr_q[k] <= prod[RW +: CW+1];
    end

    assign hit[k] = thr_q[k] > {1'b0, cnt_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       clp_q <= CLP_FREE;
    else if (strobe_i) clp_q <= clamp_e'(clamp_i);
  end

  // inner forced on while outer is on: keeps T1 and T4 apart
  always_comb begin
    unique case (clp_q)
      CLP_POS: cmd = 2'b11;
      CLP_NEG: cmd = 2'b00;
      CLP_MID: cmd = 2'b10;
      default: cmd = {hit[1] | hit[0], hit[0]};
    endcase
  end

  for (genvar k = 0; k < 2; k++) begin : g_pair
    npc_dt_pair #(.DTW(DTW)) i_pair (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i),
      .cmd_i  (cmd[k]),
      .dead_i (dead_i),
      .hi_o   (gate_o[k]),
      .lo_o   (gate_o[k+2])
    );
  end

  assert_no_shoot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[SW_T1] && gate_o[SW_T4]));

  assert_ref_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(strobe_i) |-> ($stable(thr_q) && $stable(clp_q)));
endmodule

// File: rtl/npc_gate_gen.sv
module npc_gate_gen
  import npc_pkg::*;
#(
  parameter int CW  = 12,
  parameter int RW  = 12,
  parameter int DTW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [CW-1:0]        peak_i,
  input  logic [DTW-1:0]       dead_i,
  input  logic [NLEG-1:0][RW:0] ref_a_i,
  input  logic [NLEG-1:0][RW:0] ref_b_i,
  input  logic [NLEG-1:0][1:0]  clamp_i,
  output logic [NLEG-1:0][3:0]  gate_o
);
  logic          run_q;
  logic [CW-1:0] cnt, peak;
  logic          strobe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  npc_carrier #(.CW(CW)) i_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .peak_i   (peak_i),
    .cnt_o    (cnt),
    .peak_o   (peak),
    .strobe_o (strobe)
  );

  for (genvar l = 0; l < NLEG; l++) begin : g_leg
    npc_leg #(.CW(CW), .RW(RW), .DTW(DTW)) i_leg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q),
      .strobe_i (strobe),
      .cnt_i    (cnt),
      .peak_i   (peak),
      .dead_i   (dead_i),
      .ref_a_i  (ref_a_i[l]),
      .ref_b_i  (ref_b_i[l]),
      .clamp_i  (clamp_i[l]),
      .gate_o   (gate_o[l])
    );
  end

  assert_disable_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (gate_o == '0));
endmodule

// File: tb/test_npc_gate_gen.sv
module test_npc_gate_gen;
  localparam int CW = 6;
  localparam int RW = 6;
  localparam int DTW = 3;
  localparam int ONE = 1 << RW;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [CW-1:0] peak = 6'd8;
  logic [DTW-1:0] dead = '0;
  logic [2:0][RW:0] ref_a = '0;
  logic [2:0][RW:0] ref_b = '0;
  logic [2:0][1:0] clamp = '0;
  logic [2:0][3:0] gate;

  always #(PERIOD/2) clk = ~clk;

  npc_gate_gen #(.CW(CW), .RW(RW), .DTW(DTW)) i_npc_gate_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .peak_i(peak), .dead_i(dead),
    .ref_a_i(ref_a), .ref_b_i(ref_b), .clamp_i(clamp), .gate_o(gate)
  );

  int chk = 0, err = 0, mon_chk = 0, mon_err = 0, shoot = 0;
  bit mon_on = 1'b0;

  // requirement model
  int m_cnt, m_pk, m_thr[3][2], m_clp[3], m_tmr[3][2];
  bit m_up, m_run, m_want[3][2];

  function automatic int mscale(int r, int pk);
    int s = (r > ONE) ? ONE : r;
    return (s * (pk + 1)) >> RW;
  endfunction

  function automatic bit mcmd(int l, int k);
    bit ca, cb;
    ca = m_thr[l][0] > m_cnt;
    cb = (m_thr[l][1] > m_cnt) || ca;
    case (m_clp[l])
      1: begin ca = 1; cb = 1; end
      2: begin ca = 0; cb = 0; end
      3: begin ca = 0; cb = 1; end
      default: ;
    endcase
    return k ? cb : ca;
  endfunction

  function automatic logic [3:0] mgate(int l);
    logic [3:0] g = '0;
    for (int k = 0; k < 2; k++) begin
      if (m_run && m_tmr[l][k] == 0) begin
        g[k]   = m_want[l][k];
        g[k+2] = ~m_want[l][k];
      end
    end
    return g;
  endfunction

  function automatic int duty(int t, int p);
    if (t == 0) return 0;
    if (t > p) return 2 * p;
    return 2 * t - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit stb;
    bit c;
    if (!rst_n) begin
      m_cnt <= 0; m_pk <= 0; m_up <= 1; m_run <= 0;
      for (int l = 0; l < 3; l++) begin
        m_clp[l] <= 0;
        for (int k = 0; k < 2; k++) begin
          m_thr[l][k] <= 0; m_tmr[l][k] <= 0; m_want[l][k] <= 0;
        end
      end
    end else begin
      stb = (m_cnt == 0) || (m_cnt == m_pk);
      for (int l = 0; l < 3; l++) begin
        if (stb) begin
          m_thr[l][0] <= mscale(int'(ref_a[l]), m_pk);
          m_thr[l][1] <= mscale(int'(ref_b[l]), m_pk);
          m_clp[l] <= int'(clamp[l]);
        end
        for (int k = 0; k < 2; k++) begin
          c = mcmd(l, k);
          if (!m_run || c != m_want[l][k]) begin
            m_want[l][k] <= c; m_tmr[l][k] <= int'(dead);
          end else if (m_tmr[l][k] > 0) m_tmr[l][k] <= m_tmr[l][k] - 1;
        end
      end
      m_run <= en;
      if (m_cnt == 0) m_pk <= int'(peak);
      if (m_cnt == 0) begin m_up <= 1; m_cnt <= (m_pk != 0) ? 1 : 0; end
      else if (m_up && m_cnt >= m_pk) begin m_up <= 0; m_cnt <= m_cnt - 1; end
      else m_cnt <= m_up ? m_cnt + 1 : m_cnt - 1;
    end
  end

  // lockstep compare of all twelve gates (R2/R4/R5)
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      for (int l = 0; l < 3; l++) begin
        mon_chk++;
        if (gate[l] !== mgate(l)) begin
          mon_err++;
          $display("FAIL R2/R4/R5 leg %0d gates %b expected %b", l, gate[l], mgate(l));
        end
        if (gate[l][0] && gate[l][3]) shoot++;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    chk++;
    if (!ok) begin
      err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", chk + mon_chk, err + mon_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk++; err++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end

  initial begin
    int p, t0, t1, n, cnt1, cnt2, tog;
    logic [2:0][3:0] g0;
    tick(3);
    check(gate == '0, "R9 gates in reset", int'(gate), 0);
    rst_n = 1'b1;
    tick(2);
    check(gate == '0, "R9 gates after reset", int'(gate), 0);
    mon_on = 1'b1;
    en = 1'b1;

    // duty sweep over two configurations
    for (int cfg = 0; cfg < 2; cfg++) begin
      p = cfg ? 7 : 5;
      peak = CW'(p);
      dead = cfg ? 3'd2 : 3'd0;
      tick(4 * 8 + 4);
      for (int ra = 0; ra <= 72; ra += 9) begin
        for (int rb = 0; rb <= 72; rb += 9) begin
          for (int l = 0; l < 3; l++) begin
            ref_a[l] = (l == 1) ? 7'(rb) : 7'(ra);
            ref_b[l] = (l == 1) ? 7'(ra) : ((l == 2) ? 7'(ra) : 7'(rb));
          end
          tick(2 * p + 2);
          if (cfg == 0) begin
            while (m_cnt != 0) tick(1);
            cnt1 = 0; cnt2 = 0;
            for (int i = 0; i < 2 * p; i++) begin
              cnt1 += int'(gate[0][0]);
              cnt2 += int'(gate[0][1]);
              tick(1);
            end
            t0 = mscale(ra, p); t1 = mscale(rb, p);
            check(cnt1 == duty(t0, p), "R2 outer duty", cnt1, duty(t0, p));
            check(cnt2 == duty((t1 > t0) ? t1 : t0, p), "R6 inner duty with interlock",
                  cnt2, duty((t1 > t0) ? t1 : t0, p));
          end
        end
      end
    end
    check(shoot == 0, "R6 T1 with T4", shoot, 0);

    // R1 carrier period from single-count threshold
    peak = 6'd7; dead = '0;
    ref_a = '0; ref_b = '0;
    ref_a[0] = 7'd8;
    tick(40);
    while (!(gate[0][0] == 1'b0)) tick(1);
    while (gate[0][0] == 1'b0) tick(1);
    n = 0;
    tick(1); n++;
    while (gate[0][0] == 1'b0) begin tick(1); n++; end
    check(n == 14, "R1 carrier period", n, 14);

    // R5 dead gap
    dead = 3'd3;
    ref_a[0] = 7'd32;
    tick(40);
    while (gate[0][0] == 1'b0) tick(1);
    while (gate[0][0] == 1'b1) tick(1);
    n = 0;
    while (gate[0][2] == 1'b0 && n < 20) begin n++; tick(1); end
    check(n == 3, "R5 dead gap", n, 3);

    // R3 latch only at extremes
    dead = '0;
    ref_a = '0;
    tick(40);
    while (!(m_cnt == 2 && m_up)) tick(1);
    ref_a[0] = 7'd64;
    for (int i = 0; i < 3; i++) begin
      tick(1);
      check(gate[0][0] == 1'b0, "R3 no mid-ramp update", int'(gate[0][0]), 0);
    end
    tick(8);
    check(gate[0][0] == 1'b1, "R3 update after extreme", int'(gate[0][0]), 1);

    // R7 clamp codes
    dead = 3'd1;
    ref_a = '0; ref_b = '0;
    for (int l = 0; l < 3; l++) begin ref_a[l] = 7'd32; ref_b[l] = 7'd20; end
    clamp[0] = 2'd1; clamp[1] = 2'd2; clamp[2] = 2'd3;
    tick(2 * 7 + 6);
    g0 = gate; tog = 0;
    for (int i = 0; i < 16; i++) begin
      tick(1);
      if (gate != g0) tog++;
    end
    check(tog == 0, "R7 clamped legs static", tog, 0);
    check(gate[0] == 4'b0011, "R7 code 1 holds T1 T2", int'(gate[0]), 3);
    check(gate[1] == 4'b1100, "R7 code 2 holds T3 T4", int'(gate[1]), 12);
    check(gate[2] == 4'b0110, "R7 code 3 holds T2 T3", int'(gate[2]), 6);
    clamp = '0;
    tick(20);

    // R8 disable and restart
    dead = 3'd3;
    en = 1'b0;
    tick(1);
    check(gate == '0, "R8 off one clock after disable", int'(gate), 0);
    tick(5);
    check(gate == '0, "R8 off while disabled", int'(gate), 0);
    en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(1);
      check(gate == '0, "R8 dead time after enable", int'(gate), 0);
    end
    tick(1);
    check(gate[0] != '0, "R8 gates on after dead time", int'(gate[0]), 1);
    tick(30);

    mon_on = 1'b0;
    finish_run();
  end
endmodule